// File: doc/BRIEF.md
# UART Host Register Bank with Interrupt Identification

This block is the processor-facing side of a classic byte-wide UART. A host reaches eight 8-bit registers through a 3-bit offset and separate read and write strobes. The registers are: receive buffer, transmit holding, interrupt enable, interrupt identification, line control, modem control, line status, modem status and a scratch byte. Writing a byte to the transmit holding offset hands it to a serial engine through a one-cycle valid/data port. A byte arriving on the receive valid/data port lands in the receive buffer. One active-high interrupt line signals the most urgent pending cause.

A divisor-latch switch in the line control register remaps offsets 0 and 1 onto a 16-bit baud divisor. The divisor leaves the block on its own port, together with the decoded frame format, for an external baud generator and shifter.

The transmit-empty interrupt is driven by a hidden pending flag rather than by a status bit. Reading the identification register while it reports transmit-empty consumes that flag. Writing the enable register re-arms it, because the holding register always reads empty in this block.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, offset 5 reads 0x60, offset 2 reads 0x01, offsets 1, 3, 4 and 7 read 0x00, and both `irq` and `tx_valid` are low.
- R2: While line-control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The transmit port and the enable register are then untouched. `divisor` always shows the 16-bit value.
- R3: A write to offset 1 with line-control bit 7 clear stores only wdata bits 3:0 (bits 7:4 read back as 0) and sets the transmit pending flag.
- R4: Offset 2 reads a fixed-priority code. It is 0x04 if data-ready is set and enable bit 0 is 1. Otherwise it is 0x02 if transmit pending is set and enable bit 1 is 1. Otherwise it is 0x06 if a modem change is pending and enable bit 2 is 1. Otherwise it is 0x01.
- R5: A read of offset 2 that returns 0x02 clears the transmit pending flag. Every read of offset 2 clears the modem-change flag.
- R6: A write to offset 0 with line-control bit 7 clear makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written byte. It also sets the transmit pending flag. Offset 5 keeps bits 6 and 5 at 1.
- R7: A read of offset 0 with line-control bit 7 clear returns the receive buffer and clears data-ready, which is offset 5 bit 0 (bit 4, break, always reads 0).
- R8: A `rx_valid` byte is accepted only while data-ready is clear: it loads the buffer and sets data-ready. Otherwise it is dropped, the buffer keeps its value and `rx_reject` is high for the next cycle.
- R9: Offset 4 stores only wdata bits 4:0. Offset 7 stores all 8 bits. Writes to offsets 2, 5 and 6 change nothing.
- R10: From line control: `data_bits` = bits 1:0 plus 5, `two_stop` = bit 2, `parity_en` = bit 3, `parity_even` = bit 4, `break_ctl` = bit 6.
- R11: `irq` is registered. It equals, one cycle late, whether the identification code differs from 0x01.
- R12: Any change on `ms_lines` sets the modem-change flag. Offset 6 reads `ms_lines` in bits 7:4 and 0 in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects at next edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for current offset (combinational) |
| irq | output | 1 | Interrupt request, active high |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_reject | output | 1 | Received byte dropped |
| ms_lines | input | 4 | Modem input lines |
| divisor | output | 16 | Baud divisor |
| data_bits | output | 4 | Data bits per frame (5..8) |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity when enabled |
| break_ctl | output | 1 | Break control |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after driving the strobe. The side effects of that read are visible to the next access. Register updates, `tx_valid` and `rx_reject` come one edge after the strobe, and the bench samples them at the falling edge just after that edge. `irq` lags the flags by one more edge. The bench checks that it still holds its old value at the first falling edge and has the new value at the second. A table of write/read-back vectors covers masking and ignored writes. Directed sequences then walk the interrupt priority chain and the rules that clear each flag.

// File: rtl/uart_host_regs.sv
module uart_host_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        irq,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_reject,
  input  logic [3:0]  ms_lines,
  output logic [15:0] divisor,
  output logic [3:0]  data_bits,
  output logic        two_stop,
  output logic        parity_en,
  output logic        parity_even,
  output logic        break_ctl
);

  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_THR  = 8'h02;
  localparam logic [7:0] ID_RX   = 8'h04;
  localparam logic [7:0] ID_MS   = 8'h06;

  logic [7:0] rbr, lcr, scr, ident;
  logic [3:0] ier, ms_prev;
  logic [4:0] mcr;
  logic       dr, thr_pend, ms_chg;

  wire dlab   = lcr[7];
  wire wr_dat = wr_en && addr == 3'd0 && !dlab;
  wire wr_dll = wr_en && addr == 3'd0 &&  dlab;
  wire wr_ier = wr_en && addr == 3'd1 && !dlab;
  wire wr_dlm = wr_en && addr == 3'd1 &&  dlab;
  wire rd_rbr = rd_en && addr == 3'd0 && !dlab;
  wire rd_iir = rd_en && addr == 3'd2;
  wire rx_ok  = rx_valid && !dr;

  assign data_bits   = {2'b00, lcr[1:0]} + 4'd5;
  assign two_stop    = lcr[2];
  assign parity_en   = lcr[3];
  assign parity_even = lcr[4];
  assign break_ctl   = lcr[6];

  always_comb begin
    if (dr && ier[0])            ident = ID_RX;
    else if (thr_pend && ier[1]) ident = ID_THR;
    else if (ms_chg && ier[2])   ident = ID_MS;
    else                         ident = ID_NONE;
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = dlab ? divisor[7:0]  : rbr;
      3'd1:    rdata = dlab ? divisor[15:8] : {4'b0000, ier};
      3'd2:    rdata = ident;
      3'd3:    rdata = lcr;
      3'd4:    rdata = {3'b000, mcr};
      3'd5:    rdata = {7'b0110000, dr};
      3'd6:    rdata = {ms_lines, 4'b0000};
      default: rdata = scr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbr <= '0; lcr <= '0; scr <= '0; ier <= '0; mcr <= '0;
      divisor <= '0; dr <= 1'b0; thr_pend <= 1'b0; ms_chg <= 1'b0;
      ms_prev <= '0; tx_valid <= 1'b0; tx_data <= '0;
      rx_reject <= 1'b0; irq <= 1'b0;
    end else begin
      tx_valid  <= wr_dat;
      rx_reject <= rx_valid && dr;
      irq       <= ident != ID_NONE;
      ms_prev   <= ms_lines;
      if (wr_dat) tx_data <= wdata;
      if (wr_dll) divisor[7:0]  <= wdata;
      if (wr_dlm) divisor[15:8] <= wdata;
      if (wr_ier) ier <= wdata[3:0];
      if (wr_en && addr == 3'd3) lcr <= wdata;
      if (wr_en && addr == 3'd4) mcr <= wdata[4:0];
      if (wr_en && addr == 3'd7) scr <= wdata;
      if (wr_dat || wr_ier)                 thr_pend <= 1'b1;
      else if (rd_iir && ident == ID_THR)   thr_pend <= 1'b0;
      if (ms_lines != ms_prev) ms_chg <= 1'b1;
      else if (rd_iir)         ms_chg <= 1'b0;
      if (rx_ok) begin
        rbr <= rx_data;
        dr  <= 1'b1;
      end else if (rd_rbr) begin
        dr  <= 1'b0;
      end
    end
  end

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(ident) != ID_NONE));

  // R8
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && dr) |=> rx_reject && $stable(rbr) && dr);

  // R8
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !dr) |=> dr && rbr == $past(rx_data));

  // R6
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> tx_valid && tx_data == $past(wdata) && thr_pend);

  // R3
  ier_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ier |=> thr_pend && ier == $past(wdata[3:0]));

  // R5
  iir_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && ident == ID_THR && !wr_en) |=> !thr_pend);

  // R2
  dlab_tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && dlab) |=> !tx_valid);

endmodule

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0, rx_valid = 0;
  logic [7:0] wdata = 0, rx_data = 0;
  logic [3:0] ms_lines = 0;
  logic [7:0] rdata, tx_data;
  logic irq, tx_valid, rx_reject, two_stop, parity_en, parity_even, break_ctl;
  logic [15:0] divisor;
  logic [3:0] data_bits;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_host_regs uut (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata, .irq,
    .tx_valid, .tx_data, .rx_valid, .rx_data, .rx_reject, .ms_lines, .divisor,
    .data_bits, .two_stop, .parity_en, .parity_even, .break_ctl);

  // {waddr, wdata, raddr, expected}
  localparam int NV = 9;
  localparam logic [21:0] VEC [NV] = '{
    {3'd7, 8'hA5, 3'd7, 8'hA5},
    {3'd7, 8'h3C, 3'd7, 8'h3C},
    {3'd4, 8'hFF, 3'd4, 8'h1F},
    {3'd3, 8'h1B, 3'd3, 8'h1B},
    {3'd3, 8'h00, 3'd3, 8'h00},
    {3'd1, 8'hFF, 3'd1, 8'h0F},
    {3'd5, 8'h00, 3'd5, 8'h60},
    {3'd6, 8'hFF, 3'd6, 8'h00},
    {3'd2, 8'hFF, 3'd1, 8'h0F}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rx(logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    rd(3'd5, v); chk("R1 lsr", v, 8'h60);
    rd(3'd2, v); chk("R1 iir", v, 8'h01);
    rd(3'd1, v); chk("R1 ier", v, 8'h00);
    rd(3'd3, v); chk("R1 lcr", v, 8'h00);
    rd(3'd4, v); chk("R1 mcr", v, 8'h00);
    rd(3'd7, v); chk("R1 scr", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);

    // table: R3 R9 R10 masking and ignored writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][21:19], VEC[i][18:11]);
      rd(VEC[i][10:8], v);
      chk($sformatf("R9 vector %0d", i), v, VEC[i][7:0]);
    end

    do_reset();
    // R2 divisor latch
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    chk("R2 no tx in dlab", tx_valid, 0);
    wr(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    rd(3'd0, v); chk("R2 dll read", v, 8'h34);
    rd(3'd1, v); chk("R2 dlm read", v, 8'h12);
    wr(3'd3, 8'h03);
    rd(3'd1, v); chk("R2 ier untouched", v, 8'h00);

    // R10 frame decode
    wr(3'd3, 8'h5F);
    chk("R10 bits", data_bits, 8);
    chk("R10 fmt", {two_stop, parity_en, parity_even, break_ctl}, 4'b1111);
    wr(3'd3, 8'h08);
    chk("R10 bits5", data_bits, 5);
    chk("R10 fmt2", {two_stop, parity_en, parity_even, break_ctl}, 4'b0100);
    wr(3'd3, 8'h00);

    // R6 transmit
    wr(3'd0, 8'h5A);
    chk("R6 tx_valid", tx_valid, 1);
    chk("R6 tx_data", tx_data, 8'h5A);
    @(negedge clk);
    chk("R6 single pulse", tx_valid, 0);
    rd(3'd5, v); chk("R6 lsr", v, 8'h60);

    // R3 R11 R4 R5 transmit-empty interrupt
    wr(3'd1, 8'h02);
    chk("R11 irq lag", irq, 0);
    @(negedge clk);
    chk("R11 irq up", irq, 1);
    rd(3'd2, v); chk("R4 thr id", v, 8'h02);
    @(negedge clk);
    chk("R5 irq down", irq, 0);
    rd(3'd2, v); chk("R5 thr consumed", v, 8'h01);

    // R8 R7 receive
    wr(3'd1, 8'h00);
    rx(8'h77);
    rd(3'd5, v); chk("R8 dr set", v, 8'h61);
    rx(8'h88);
    chk("R8 reject", rx_reject, 1);
    rd(3'd0, v); chk("R7 rbr kept", v, 8'h77);
    rd(3'd5, v); chk("R7 dr clear", v, 8'h60);
    chk("R8 reject pulse gone", rx_reject, 0);

    // R4 priority chain, R12 modem change
    wr(3'd1, 8'h07);
    rx(8'h11);
    rd(3'd2, v); chk("R4 rx first", v, 8'h04);
    rd(3'd0, v); chk("R7 rbr", v, 8'h11);
    rd(3'd2, v); chk("R4 thr second", v, 8'h02);
    @(negedge clk); ms_lines = 4'h9;
    repeat (2) @(negedge clk);
    rd(3'd6, v); chk("R12 ms read", v, 8'h90);
    rd(3'd2, v); chk("R12 ms id", v, 8'h06);
    rd(3'd2, v); chk("R5 ms cleared", v, 8'h01);
    @(negedge clk);
    chk("R11 irq idle", irq, 0);

    finish_run();
  end
endmodule